// File: doc/BRIEF.md
# Successive Approximation Conversion Sequencer

This block steps an analog-to-digital conversion by binary search. A single-cycle start request, taken only while the sequencer is idle, loads a trial code with just its top bit set and drives that code to an external DAC. On each following clock the block reads one digital comparator input, which is high when the sampled input is at or above the trial level. It keeps or drops the bit under test, then sets the next lower bit. A busy status stays high for the whole search. When the last bit is decided the result register is loaded and marked valid.

A width select is sampled together with the start request. It picks either a full search over every bit or a shortened search over the upper bits only. A shortened result carries a fixed marker in its unused low bits: the highest of those bits is one and the others are zero. The DAC, the comparator and the analog scaling are outside this block. The bus logic that produces the start request is a separate block.

Top module: `sar_conv_seq`

## Requirements
- R1: A start request while idle raises `busy_o` on the next clock, and from that clock `dac_code_o` shows only its most significant bit set.
- R2: A full conversion keeps `busy_o` high for exactly FULL_BITS (12) cycles and ends with `result_o` equal to the largest code not above the input, which is the result of the binary search.
- R3: A short conversion keeps `busy_o` high for exactly SHORT_BITS (8) cycles.
- R4: After a short conversion, `result_o[11:4]` holds the decided upper bits, `result_o[3]` is 1 and `result_o[2:0]` are 0.
- R5: `result_valid_o` is low from the clock after an accepted start until the last bit is decided, and high from the clock in which `busy_o` falls.
- R6: `result_o` does not change while `busy_o` is high, so a read during a conversion returns the previous result.
- R7: A start request while `busy_o` is high has no effect: the conversion length and the result are unchanged.
- R8: Reset, including reset during a conversion, sets `busy_o`, `result_valid_o`, `result_o` and `dac_code_o` to 0.
- R9: The width select is sampled only with an accepted start. Changing `short_i` during a conversion does not change its length or its result.
- R10: In busy cycle k (k = 0 first), `dac_code_o` holds the already decided bits above position 11-k, a 1 at position 11-k, and 0 below it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Single-cycle conversion request |
| short_i | input | 1 | 1 selects the shortened conversion, sampled with the start |
| cmp_above_i | input | 1 | Comparator: input at or above the current trial level |
| dac_code_o | output | 12 | Trial code to the DAC |
| busy_o | output | 1 | High while a conversion runs |
| result_o | output | 12 | Last completed result |
| result_valid_o | output | 1 | Result complete and not being replaced |

## Verification
A wrong bit pointer or trial register shows up on `dac_code_o` in the first busy cycle in which it goes wrong, because the bench checks the expected trial pattern in every cycle. A wrong end-of-search decision changes the number of busy cycles, and a wrong latched width select changes both the busy count and the low result bits. Both are seen when `busy_o` falls. A result register that loads too early is caught during the conversion, while the previous result is still expected on `result_o`.

// File: rtl/sar_pkg.sv
package sar_pkg;
  typedef enum logic {
    SAR_IDLE = 1'b0,
    SAR_RUN  = 1'b1
  } sar_state_e;
endpackage

// File: rtl/sar_bit_ptr.sv
module sar_bit_ptr #(
  parameter int FULL_BITS = 12,
  parameter int SHORT_LSB = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load_i,
  input  logic                 step_i,
  input  logic                 short_i,
  output logic [FULL_BITS-1:0] ptr_o,
  output logic                 last_o
);
  localparam logic [FULL_BITS-1:0] MSB_ONE = {1'b1, {(FULL_BITS-1){1'b0}}};

  logic [FULL_BITS-1:0] ptr_q, ptr_d;
  logic                 ptr_en;

  assign ptr_en = load_i | step_i;
  assign last_o = short_i ? ptr_q[SHORT_LSB] : ptr_q[0];

  always_comb begin
    ptr_d = ptr_q;
    if (load_i)      ptr_d = MSB_ONE;
    else if (last_o) ptr_d = '0;
    else             ptr_d = ptr_q >> 1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ptr_q <= '0;
    else if (ptr_en) ptr_q <= ptr_d;
  end

  assign ptr_o = ptr_q;

  // R10
  ptr_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ptr_q));

  // R10
  ptr_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_i |-> (ptr_q != '0));
endmodule

// File: rtl/sar_trial_reg.sv
module sar_trial_reg #(
  parameter int FULL_BITS = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load_i,
  input  logic                 step_i,
  input  logic [FULL_BITS-1:0] ptr_i,
  input  logic                 cmp_above_i,
  output logic [FULL_BITS-1:0] trial_o,
  output logic [FULL_BITS-1:0] decided_o
);
  localparam logic [FULL_BITS-1:0] MSB_ONE = {1'b1, {(FULL_BITS-1){1'b0}}};

  logic [FULL_BITS-1:0] trial_q, trial_d;
  logic                 trial_en;

  assign decided_o = cmp_above_i ? trial_q : (trial_q & ~ptr_i);
  assign trial_en  = load_i | step_i;

  always_comb begin
    if (load_i) trial_d = MSB_ONE;
    else        trial_d = decided_o | (ptr_i >> 1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        trial_q <= '0;
    else if (trial_en) trial_q <= trial_d;
  end

  assign trial_o = trial_q;

  // R10
  trial_bit_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_i |-> ((trial_q & ptr_i) != '0));

  // R10
  trial_low_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_i |-> ((trial_q & (ptr_i - 1'b1)) == '0));
endmodule

// File: rtl/sar_result_reg.sv
module sar_result_reg #(
  parameter int FULL_BITS = 12,
  parameter int SHORT_LSB = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 capture_i,
  input  logic                 short_i,
  input  logic [FULL_BITS-1:0] decided_i,
  output logic [FULL_BITS-1:0] result_o
);
  logic [FULL_BITS-1:0] res_q, res_d;

  generate
    if (SHORT_LSB > 0) begin : g_marker
      localparam logic [SHORT_LSB-1:0] MARK = SHORT_LSB'(1) << (SHORT_LSB - 1);
      always_comb begin
        res_d = decided_i;
        if (short_i) res_d[SHORT_LSB-1:0] = MARK;
      end
    end else begin : g_plain
      always_comb res_d = decided_i;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         res_q <= '0;
    else if (capture_i) res_q <= res_d;
  end

  assign result_o = res_q;
endmodule

// File: rtl/sar_conv_seq.sv
module sar_conv_seq #(
  parameter int FULL_BITS  = 12,
  parameter int SHORT_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start_i,
  input  logic                 short_i,
  input  logic                 cmp_above_i,
  output logic [FULL_BITS-1:0] dac_code_o,
  output logic                 busy_o,
  output logic [FULL_BITS-1:0] result_o,
  output logic                 result_valid_o
);
  import sar_pkg::*;

  localparam int SHORT_LSB = FULL_BITS - SHORT_BITS;
  localparam logic [FULL_BITS-1:0] MSB_ONE = {1'b1, {(FULL_BITS-1){1'b0}}};

  sar_state_e           state_q, state_d;
  logic                 short_q, short_d;
  logic                 valid_q, valid_d;
  logic                 start_ok, step, last, finish;
  logic [FULL_BITS-1:0] ptr, decided;

  assign start_ok = start_i && (state_q == SAR_IDLE);
  assign step     = (state_q == SAR_RUN);
  assign finish   = step && last;

  always_comb begin
    state_d = state_q;
    case (state_q)
      SAR_IDLE: if (start_ok) state_d = SAR_RUN;
      SAR_RUN:  if (last)     state_d = SAR_IDLE;
      default:                state_d = SAR_IDLE;
    endcase
    short_d = start_ok ? short_i : short_q;
    if (start_ok)    valid_d = 1'b0;
    else if (finish) valid_d = 1'b1;
    else             valid_d = valid_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SAR_IDLE;
      short_q <= 1'b0;
      valid_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (start_ok) short_q <= short_d;
      valid_q <= valid_d;
    end
  end

  sar_bit_ptr #(.FULL_BITS(FULL_BITS), .SHORT_LSB(SHORT_LSB)) u_ptr (
    .clk(clk), .rst_n(rst_n), .load_i(start_ok), .step_i(step),
    .short_i(short_q), .ptr_o(ptr), .last_o(last)
  );

  sar_trial_reg #(.FULL_BITS(FULL_BITS)) u_trial (
    .clk(clk), .rst_n(rst_n), .load_i(start_ok), .step_i(step),
    .ptr_i(ptr), .cmp_above_i(cmp_above_i),
    .trial_o(dac_code_o), .decided_o(decided)
  );

  sar_result_reg #(.FULL_BITS(FULL_BITS), .SHORT_LSB(SHORT_LSB)) u_res (
    .clk(clk), .rst_n(rst_n), .capture_i(finish), .short_i(short_q),
    .decided_i(decided), .result_o(result_o)
  );

  assign busy_o         = step;
  assign result_valid_o = valid_q;

  // R1
  start_msb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> (dac_code_o == MSB_ONE));

  // R5
  no_valid_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> !result_valid_o);

  // R5
  valid_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> result_valid_o);

  // R6
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> $stable(result_o));

  // R9
  short_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && $past(busy_o)) |-> $stable(short_q));

  generate
    if (SHORT_LSB > 0) begin : g_mark_chk
      // R4
      short_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy_o) && short_q) |->
          (result_o[SHORT_LSB-1:0] == (SHORT_LSB'(1) << (SHORT_LSB - 1))));
    end
  endgenerate
endmodule

// File: tb/tb_sar_conv_seq.sv
module tb_sar_conv_seq;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        start_i;
  logic        short_i;
  logic        cmp_above_i;
  logic [11:0] dac_code_o;
  logic        busy_o;
  logic [11:0] result_o;
  logic        result_valid_o;
  logic [11:0] vin;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  assign cmp_above_i = (vin >= dac_code_o);

  sar_conv_seq dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .short_i(short_i),
    .cmp_above_i(cmp_above_i), .dac_code_o(dac_code_o), .busy_o(busy_o),
    .result_o(result_o), .result_valid_o(result_valid_o)
  );

  // {short, input level}
  localparam logic [12:0] VEC [10] = '{
    {1'b0, 12'hA5C}, {1'b0, 12'h000}, {1'b0, 12'hFFF}, {1'b0, 12'h800},
    {1'b0, 12'h7FF}, {1'b1, 12'h3C7}, {1'b1, 12'hFFF}, {1'b1, 12'h000},
    {1'b1, 12'h80F}, {1'b0, 12'h001}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [11:0] expect_res(input logic [11:0] v, input bit sh);
    return sh ? {v[11:4], 4'b1000} : v;
  endfunction

  // Runs one conversion; optionally pulses start with flipped short mid-run.
  task automatic convert(input logic [11:0] v, input bit sh, input bit poke);
    int cyc;
    logic [11:0] prev, exp_dac;
    prev = result_o;
    @(negedge clk);
    vin = v; short_i = sh; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    check(busy_o == 1'b1, "R1", busy_o, 1);
    check(dac_code_o == 12'h800, "R1", dac_code_o, 12'h800);
    cyc = 0;
    while (busy_o && cyc < 40) begin
      exp_dac = (v & ~((12'h1 << (12 - cyc)) - 12'h1)) | (12'h1 << (11 - cyc));
      if (cyc == 0) exp_dac = 12'h800;
      check(dac_code_o == exp_dac, "R10", dac_code_o, exp_dac);
      check(result_valid_o == 1'b0, "R5", result_valid_o, 0);
      check(result_o == prev, "R6", result_o, prev);
      if (poke && cyc == 3) begin start_i = 1'b1; short_i = ~sh; end
      else begin start_i = 1'b0; short_i = sh; end
      cyc++;
      @(negedge clk);
    end
    start_i = 1'b0;
    check(cyc == (sh ? 8 : 12), sh ? "R3" : "R2", cyc, sh ? 8 : 12);
    check(result_valid_o == 1'b1, "R5", result_valid_o, 1);
    check(result_o == expect_res(v, sh), sh ? "R4" : "R2", result_o, expect_res(v, sh));
    if (poke) begin
      check(busy_o == 1'b0, "R7", busy_o, 0);
      check(cyc == (sh ? 8 : 12), "R9", cyc, sh ? 8 : 12);
    end
  endtask

  initial begin
    #(200000 * 4);
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start_i = 1'b0; short_i = 1'b0; vin = '0;
    repeat (3) @(negedge clk);
    check(busy_o == 0 && result_valid_o == 0, "R8", {busy_o, result_valid_o}, 0);
    check(result_o == 0 && dac_code_o == 0, "R8", result_o | dac_code_o, 0);
    rst_n = 1'b1;

    for (int i = 0; i < 10; i++) convert(VEC[i][11:0], VEC[i][12], 1'b0);

    // R7 and R9: start request with the other width while busy
    convert(12'h5A3, 1'b0, 1'b1);
    convert(12'hC3B, 1'b1, 1'b1);

    // R6: result stays at the previous value through a new conversion
    convert(12'h123, 1'b0, 1'b0);

    // R8: reset during a conversion
    @(negedge clk);
    vin = 12'h9AB; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check(busy_o == 0 && result_valid_o == 0, "R8", {busy_o, result_valid_o}, 0);
    check(result_o == 0 && dac_code_o == 0, "R8", result_o | dac_code_o, 0);
    rst_n = 1'b1;
    convert(12'h9AB, 1'b0, 1'b0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule